// File: doc/BRIEF.md
# Pipeline RAW Hazard Interlock

This block makes the control decisions for read-after-write hazards in an in-order five-stage integer pipeline (fetch, decode, execute, memory, writeback). Every cycle it compares the two source register numbers of the instruction in decode with the destination registers of the older instructions still in execute, memory and writeback. When one of those older instructions will write a source, it selects a forwarding path for that operand. Dependent instructions therefore need no NOPs between them.

Only one dependency cannot be covered by bypassing: a load in execute whose result is needed by the instruction in decode. For that case the block freezes fetch and decode for one cycle and puts a bubble into execute. The load moves on to memory, where its data can be forwarded. A stall request from outside the pipeline, such as a cache miss, is a separate input. It freezes every stage and is never counted as an interlock. The block keeps its own valid, destination, write-enable and load flags for the execute, memory and writeback stages, so its view of the pipe advances in step with the datapath it controls.

Top module: `hz_interlock`

## Requirements
- R1: A load-use stall is raised when the decode instruction is valid, execute holds a valid writing load with destination not 0, and that destination equals either source of the decode instruction; `stall_front_o` and `bubble_ex_o` are then 1 in the same cycle.
- R2: `stall_front_o` is 1 whenever a load-use stall or `ext_stall_i` is present, and 0 otherwise.
- R3: After a load-use cycle, execute holds a bubble (no forwarding from execute is possible) and the load has moved to memory, so a still-dependent operand selects 2'b10.
- R4: A match on a non-load instruction in execute, memory or writeback never stalls; the forwarding path is selected instead.
- R5: While `ext_stall_i` is 1, all tracked stages hold, `freeze_back_o` is 1, and `bubble_ex_o` and `interlock_event_o` are 0 even if a load-use dependency is present.
- R6: A load-use dependency costs exactly one stall cycle when no external stall intervenes.
- R7: Source register 0 never selects forwarding or causes a stall. Invalid decode or stage entries, and entries with write-enable 0, never create a dependency.
- R8: Each operand's select is 2'b11 for execute, 2'b10 for memory, 2'b01 for writeback and 2'b00 for the register file. The youngest matching stage wins. The select is 2'b00 when decode is invalid.
- R9: `interlock_event_o` is 1 for exactly the cycles in which a bubble is injected, and only for those cycles.
- R10: After reset, all stages are empty: no stall, no bubble, all selects 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode holds a real instruction |
| id_rs1_i | input | REG_W | First source register of decode instruction |
| id_rs2_i | input | REG_W | Second source register of decode instruction |
| id_rd_i | input | REG_W | Destination register of decode instruction |
| id_wen_i | input | 1 | Decode instruction writes its destination |
| id_load_i | input | 1 | Decode instruction is a load |
| ext_stall_i | input | 1 | Stall request from outside the pipeline |
| fwd_rs1_o | output | 2 | Forwarding select for the first operand |
| fwd_rs2_o | output | 2 | Forwarding select for the second operand |
| stall_front_o | output | 1 | Freeze fetch and decode |
| freeze_back_o | output | 1 | Freeze execute, memory and writeback |
| bubble_ex_o | output | 1 | Load a bubble into execute at the next edge |
| interlock_event_o | output | 1 | One pulse per inserted interlock stall cycle |

## Verification
The stall, bubble, event and forwarding outputs are combinational. Each is due in the same cycle as the decode inputs, computed from stage state set by the edges before. The bench drives its inputs on the falling edge and samples those outputs shortly afterwards. Only at the following rising edge does it step its own model of execute, memory and writeback: shift, bubble insertion or a full hold. A bubble is seen one edge later, as a select that has moved from execute to memory, and the stall count per load is checked the same way.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned NUM_STG = 3;  // execute, memory, writeback
  localparam int unsigned SEL_W   = 2;
  typedef enum logic [SEL_W-1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10,
    FWD_EX  = 2'b11
  } fwd_sel_e;
endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned N_STG = hz_pkg::NUM_STG
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        hold_all_i,
  input  logic                        bubble_i,
  input  logic                        in_valid_i,
  input  logic [REG_W-1:0]            in_rd_i,
  input  logic                        in_wen_i,
  input  logic                        in_load_i,
  output logic [N_STG-1:0]            v_o,
  output logic [N_STG-1:0][REG_W-1:0] rd_o,
  output logic [N_STG-1:0]            wen_o,
  output logic [N_STG-1:0]            load_o
);
  logic [N_STG-1:0]            v_q, wen_q, load_q;
  logic [N_STG-1:0][REG_W-1:0] rd_q;

  // stage 0 = execute, fed from decode or a bubble
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q[0] <= 1'b0; rd_q[0] <= '0; wen_q[0] <= 1'b0; load_q[0] <= 1'b0;
    end else if (!hold_all_i) begin
      v_q[0]    <= in_valid_i & ~bubble_i;
      rd_q[0]   <= in_rd_i;
      wen_q[0]  <= in_wen_i & ~bubble_i;
      load_q[0] <= in_load_i & ~bubble_i;
    end
  end

  for (genvar s = 1; s < N_STG; s++) begin : g_shift
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[s] <= 1'b0; rd_q[s] <= '0; wen_q[s] <= 1'b0; load_q[s] <= 1'b0;
      end else if (!hold_all_i) begin
        v_q[s]    <= v_q[s-1];
        rd_q[s]   <= rd_q[s-1];
        wen_q[s]  <= wen_q[s-1];
        load_q[s] <= load_q[s-1];
      end
    end
  end

  assign v_o    = v_q;
  assign rd_o   = rd_q;
  assign wen_o  = wen_q;
  assign load_o = load_q;

  p_ext_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_all_i |=> ($stable(v_q) && $stable(rd_q) && $stable(wen_q)));
  p_bubble_drains_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bubble_i && !hold_all_i) |=> (!v_q[0] && $past(v_q[0]) == v_q[1]));
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned N_STG = hz_pkg::NUM_STG
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        id_valid_i,
  input  logic [REG_W-1:0]            src_i,
  input  logic [N_STG-1:0]            v_i,
  input  logic [N_STG-1:0][REG_W-1:0] rd_i,
  input  logic [N_STG-1:0]            wen_i,
  output logic [hz_pkg::SEL_W-1:0]    sel_o
);
  import hz_pkg::*;
  logic [N_STG-1:0] hit;

  for (genvar s = 0; s < N_STG; s++) begin : g_hit
    assign hit[s] = id_valid_i && (src_i != '0) && v_i[s] && wen_i[s] && (rd_i[s] == src_i);
  end

  // oldest first, younger stages override
  always_comb begin
    sel_o = FWD_RF;
    for (int s = N_STG - 1; s >= 0; s--) begin
      if (hit[s]) sel_o = SEL_W'(N_STG - s);
    end
  end

  p_zero_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0 || !id_valid_i) |-> (sel_o == FWD_RF));
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned REG_W = 5
) (
  input  logic             id_valid_i,
  input  logic [REG_W-1:0] rs1_i,
  input  logic [REG_W-1:0] rs2_i,
  input  logic             ex_valid_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_wen_i,
  input  logic             ex_load_i,
  output logic             hazard_o
);
  logic ex_prod;
  assign ex_prod  = ex_valid_i && ex_wen_i && ex_load_i && (ex_rd_i != '0);
  assign hazard_o = id_valid_i && ex_prod && ((ex_rd_i == rs1_i) || (ex_rd_i == rs2_i));
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             id_valid_i,
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic [REG_W-1:0] id_rd_i,
  input  logic             id_wen_i,
  input  logic             id_load_i,
  input  logic             ext_stall_i,
  output logic [1:0]       fwd_rs1_o,
  output logic [1:0]       fwd_rs2_o,
  output logic             stall_front_o,
  output logic             freeze_back_o,
  output logic             bubble_ex_o,
  output logic             interlock_event_o
);
  import hz_pkg::*;
  localparam int unsigned N_SRC = 2;

  logic [NUM_STG-1:0]            st_v, st_wen, st_load;
  logic [NUM_STG-1:0][REG_W-1:0] st_rd;
  logic [N_SRC-1:0][REG_W-1:0]   src;
  logic [N_SRC-1:0][SEL_W-1:0]   sel;
  logic                          load_use, bubble;

  assign src[0] = id_rs1_i;
  assign src[1] = id_rs2_i;

  hz_load_use #(.REG_W(REG_W)) i_load_use (
    .id_valid_i (id_valid_i),
    .rs1_i      (id_rs1_i),
    .rs2_i      (id_rs2_i),
    .ex_valid_i (st_v[0]),
    .ex_rd_i    (st_rd[0]),
    .ex_wen_i   (st_wen[0]),
    .ex_load_i  (st_load[0]),
    .hazard_o   (load_use)
  );

  // external stall wins over bubble insertion
  assign bubble = load_use & ~ext_stall_i;

  hz_stage_track #(.REG_W(REG_W), .N_STG(NUM_STG)) i_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_all_i (ext_stall_i),
    .bubble_i   (bubble),
    .in_valid_i (id_valid_i),
    .in_rd_i    (id_rd_i),
    .in_wen_i   (id_wen_i),
    .in_load_i  (id_load_i),
    .v_o        (st_v),
    .rd_o       (st_rd),
    .wen_o      (st_wen),
    .load_o     (st_load)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    hz_fwd_sel #(.REG_W(REG_W), .N_STG(NUM_STG)) i_fwd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .id_valid_i (id_valid_i),
      .src_i      (src[i]),
      .v_i        (st_v),
      .rd_i       (st_rd),
      .wen_i      (st_wen),
      .sel_o      (sel[i])
    );
  end

  assign fwd_rs1_o         = sel[0];
  assign fwd_rs2_o         = sel[1];
  assign stall_front_o     = load_use | ext_stall_i;
  assign freeze_back_o     = ext_stall_i;
  assign bubble_ex_o       = bubble;
  assign interlock_event_o = bubble;

  p_single_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interlock_event_o |=> !interlock_event_o);
  p_event_stalls_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interlock_event_o |-> (stall_front_o && !freeze_back_o));
  p_ext_no_event_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_stall_i |-> (!bubble_ex_o && !interlock_event_o && stall_front_o));
  p_after_bubble_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interlock_event_o |=> (fwd_rs1_o != 2'b11 && fwd_rs2_o != 2'b11));
endmodule

// File: tb/test_hz_interlock.sv
module test_hz_interlock;
  localparam int RW = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic id_valid = 1'b0, id_wen = 1'b0, id_load = 1'b0, ext_stall = 1'b0;
  logic [RW-1:0] rs1 = '0, rs2 = '0, rd = '0;
  logic [1:0] f1, f2;
  logic stall, freeze, bubble, ev;
  int n_run = 0, n_fail = 0;
  int ev_count = 0;

  // bench model of execute(0), memory(1), writeback(2)
  logic m_v[3], m_wen[3], m_ld[3];
  logic [RW-1:0] m_rd[3];

  always #4 clk = ~clk;

  hz_interlock #(.REG_W(RW)) i_hz_interlock (
    .clk_i(clk), .rst_ni(rst_n), .id_valid_i(id_valid), .id_rs1_i(rs1), .id_rs2_i(rs2),
    .id_rd_i(rd), .id_wen_i(id_wen), .id_load_i(id_load), .ext_stall_i(ext_stall),
    .fwd_rs1_o(f1), .fwd_rs2_o(f2), .stall_front_o(stall), .freeze_back_o(freeze),
    .bubble_ex_o(bubble), .interlock_event_o(ev));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [RW-1:0] s);
    if (!id_valid || s == 0) return 2'b00;
    if (m_v[0] && m_wen[0] && m_rd[0] == s) return 2'b11;
    if (m_v[1] && m_wen[1] && m_rd[1] == s) return 2'b10;
    if (m_v[2] && m_wen[2] && m_rd[2] == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_lu();
    return id_valid && m_v[0] && m_wen[0] && m_ld[0] && m_rd[0] != 0 &&
           (m_rd[0] == rs1 || m_rd[0] == rs2);
  endfunction

  // compare outputs mid-cycle, then step model at the edge
  task automatic step_chk();
    logic lu;
    #2;
    lu = exp_lu();
    chk("R1 bubble", bubble, lu && !ext_stall);
    chk("R2 stall_front", stall, lu || ext_stall);
    chk("R5 freeze_back", freeze, ext_stall);
    chk("R9 event", ev, lu && !ext_stall);
    chk("R8 fwd_rs1", f1, exp_sel(rs1));
    chk("R8 fwd_rs2", f2, exp_sel(rs2));
    if (ev) ev_count++;
    @(posedge clk);
    if (!ext_stall) begin
      for (int s = 2; s > 0; s--) begin
        m_v[s] = m_v[s-1]; m_wen[s] = m_wen[s-1]; m_ld[s] = m_ld[s-1]; m_rd[s] = m_rd[s-1];
      end
      m_v[0] = id_valid && !lu; m_wen[0] = id_wen && !lu; m_ld[0] = id_load && !lu; m_rd[0] = rd;
    end
    @(negedge clk);
  endtask

  task automatic issue(input logic v, input int a, input int b, input int d,
                       input logic w, input logic l, input logic x);
    id_valid = v; rs1 = RW'(a); rs2 = RW'(b); rd = RW'(d);
    id_wen = w; id_load = l; ext_stall = x;
  endtask

  initial begin
    #1_600_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic prev_stall;
    for (int s = 0; s < 3; s++) begin m_v[s] = 0; m_wen[s] = 0; m_ld[s] = 0; m_rd[s] = '0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    issue(1, 1, 2, 3, 1, 0, 0);
    #1;
    chk("R10 stall", stall, 0); chk("R10 fwd1", f1, 0); chk("R10 fwd2", f2, 0); chk("R10 bubble", bubble, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6/R3: load r3 then dependent use
    issue(1, 0, 0, 3, 1, 1, 0); step_chk();
    ev_count = 0;
    issue(1, 3, 0, 4, 1, 0, 0);
    #1; chk("R1 load-use stall", stall, 1); chk("R1 bubble", bubble, 1);
    step_chk();
    #1; chk("R3 fwd from mem", f1, 2); chk("R6 single stall", stall, 0);
    step_chk();
    chk("R6 stall count", ev_count, 1);

    // R4: ALU result forwarded, no stall; priority R8 ex over mem
    issue(1, 0, 0, 5, 1, 0, 0); step_chk();
    issue(1, 0, 0, 5, 1, 0, 0); step_chk();
    issue(1, 5, 5, 6, 1, 0, 0);
    #1; chk("R4 no stall", stall, 0); chk("R8 ex wins", f1, 3); chk("R8 ex wins b", f2, 3);
    step_chk();

    // R7: r0 load never stalls
    issue(1, 0, 0, 0, 1, 1, 0); step_chk();
    issue(1, 0, 0, 7, 1, 0, 0);
    #1; chk("R7 r0 no stall", stall, 0); chk("R7 r0 sel", f1, 0);
    step_chk();

    // R5: external stall holds a load-use without event, then it resolves
    issue(1, 0, 0, 9, 1, 1, 0); step_chk();
    issue(1, 9, 0, 1, 1, 0, 1);
    #1; chk("R5 no event", ev, 0); chk("R5 no bubble", bubble, 0); chk("R5 freeze", freeze, 1);
    step_chk(); step_chk();
    ext_stall = 0;
    #1; chk("R5 load still in ex", f1, 3); chk("R5 then interlock", ev, 1);
    step_chk(); step_chk();

    // near-exhaustive pseudo-random sweep over registers 0..3
    lfsr = 16'hACE1; prev_stall = 0;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (!prev_stall)
        issue(lfsr[0] | lfsr[1], lfsr[3:2], lfsr[5:4], lfsr[7:6], lfsr[8] | lfsr[9],
              lfsr[10] & lfsr[11], 0);
      ext_stall = (lfsr[14:12] == 3'b000);
      #1; prev_stall = stall;
      step_chk();
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule